// File: doc/BRIEF.md
# Broadcast Group-Address Membership Matcher

Each node on a shared broadcast bus holds one copy of this block. The block watches the bytes of every command packet and decides whether the packet is meant for its own node. It does not store the packet. It keeps a byte position, the addressing mode and one hit flag. When the last byte of the packet has been accepted, it raises `sel_o` for a single cycle if the node was addressed.

Bit 7 of the first byte is the type bit, and it selects one of two addressing forms. In group form, the rest of the packet is a bitmap with one bit per device. The block checks only the single byte and the single bit that belong to its node. In direct form, the second byte carries one device label, and the node is selected only when that label equals its own ID.

The packet framer feeds the block a byte strobe together with start and end markers. The framer also handles framing, CRC and command decoding.

Top module: `gam_matcher`

## Requirements
- R1: While `rst_ni` is low, and after reset until a packet completes, `sel_o` is 0. A reset in the middle of a packet discards that packet.
- R2: Bit 7 of byte 0 selects the mode: 0 means group (bitmap) form and 1 means direct (label) form. In group form, the value of byte 1 as a number has no effect. Only bitmap bits are tested.
- R3: In group form, a node with ID below 7 is addressed by bit ID of byte 0. Bits are counted from the LSB. The type bit is never read as a device bit.
- R4: In group form, a node with ID of 7 or more is addressed by bit ((ID+1) mod 8) of byte ((ID+1) div 8). Device 7 is therefore byte 1, bit 0, and device 255 is byte 32, bit 0.
- R5: In direct form, the node is selected only when byte 1 equals the node ID exactly. Bits 6..0 of byte 0 are ignored.
- R6: `sel_o` goes high for exactly one cycle, in the cycle after the byte that carries `eop_i` is accepted. It is never high at any other time. Two single-byte packets on consecutive cycles give two consecutive pulses.
- R7: A packet that ends before the byte holding the node's bit (group form) or its label (direct form) does not select the node. A packet that ends exactly on that byte can select it.
- R8: A byte is accepted only when `valid_i` is high, and only if it carries `sop_i` or belongs to an open packet. `sop_i`, `eop_i` and `data_i` are ignored while `valid_i` is low. Valid bytes that arrive after `eop_i` without a new `sop_i` are ignored.
- R9: A `sop_i` inside an open packet starts a new packet. Any hit from the abandoned packet is discarded.
- R10: A one-byte packet (`sop_i` and `eop_i` on the same byte) can select nodes 0 to 6 in group form. It never selects any node in direct form.
- R11: Bytes after the node's byte or label have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | ID_W | Static ID of this node |
| valid_i | input | 1 | Byte strobe for `data_i` |
| sop_i | input | 1 | First byte of a packet (qualified by `valid_i`) |
| eop_i | input | 1 | Last byte of a packet (qualified by `valid_i`) |
| data_i | input | 8 | Packet byte |
| sel_o | output | 1 | One-cycle pulse: the packet addressed this node |

## Verification
The bench probes the bit-position rule at its edges:
- Devices 6, 7 and 8 sit on either side of the type bit, and device 255 is the last bit of byte 32. A design that forgets the one-bit shift reads the neighbouring device's bit.
- Packets are truncated one byte short of the node's byte and exactly at it. An off-by-one counter either misses real hits or fires on a truncated packet.
- Idle cycles carry garbage strobes, stray bytes arrive after `eop_i`, and `sop_i` restarts an open packet. A design that fails to gate on `valid_i` or the open-packet state, or that carries the old hit flag across a restart, pulses when it should not.
- In direct form, the bench checks a one-byte packet and a group packet whose second byte equals the node ID. This catches a decoder that mixes up the two forms.

// File: rtl/gam_pkg.sv
package gam_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_SEL_W = $clog2(BYTE_W);

  typedef enum logic {
    MODE_GROUP  = 1'b0,
    MODE_DIRECT = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/gam_target.sv
// Maps a node ID to the byte index and bit of its bitmap slot (R3, R4).
module gam_target
  import gam_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int IDX_W = ID_W - 2
) (
  input  logic [ID_W-1:0]      node_id_i,
  output logic [IDX_W-1:0]     tgt_idx_o,
  output logic [BIT_SEL_W-1:0] tgt_bit_o
);
  localparam int POS_W = ID_W + 1;
  localparam int FIRST_BYTE_DEV = BYTE_W - 1;

  logic [POS_W-1:0] pos;

  // Byte 0 bit 7 is the type bit; devices from 7 upward move up one slot.
  always_comb begin
    if (node_id_i < ID_W'(FIRST_BYTE_DEV)) pos = {1'b0, node_id_i};
    else                                   pos = {1'b0, node_id_i} + POS_W'(1);
  end

  assign tgt_idx_o = pos[POS_W-1:BIT_SEL_W];
  assign tgt_bit_o = pos[BIT_SEL_W-1:0];

  always_comb begin
    if (tgt_idx_o == '0) begin
      a_r3_type_bit_free: assert (tgt_bit_o != BIT_SEL_W'(BYTE_W - 1));
    end
  end
endmodule

// File: rtl/gam_tracker.sv
// Tracks packet framing: open state, byte position, latched mode.
module gam_tracker
  import gam_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sop_i,
  input  logic             eop_i,
  input  logic             type_bit_i,
  output logic             acc_o,
  output logic             first_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output addr_mode_e       mode_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic             in_pkt_q;
  logic [IDX_W-1:0] cnt_q;
  addr_mode_e       mode_q;

  assign first_o = valid_i & sop_i;
  assign acc_o   = valid_i & (sop_i | in_pkt_q);
  assign last_o  = acc_o & eop_i;
  assign idx_o   = sop_i ? '0 : cnt_q;
  assign mode_o  = first_o ? addr_mode_e'(type_bit_i) : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= MODE_GROUP;
    end else if (acc_o) begin
      in_pkt_q <= ~eop_i;
      mode_q   <= mode_o;
      cnt_q    <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + IDX_W'(1);
    end
  end

  a_r8_idle_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q) && $stable(in_pkt_q) && $stable(mode_q));

  a_r9_sop_restarts_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> cnt_q == IDX_W'(1));

  a_r2_mode_from_type_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i) |=> mode_q == addr_mode_e'($past(type_bit_i)));
endmodule

// File: rtl/gam_hit.sv
// Per-byte match test, sticky hit flag and end-of-packet pulse.
module gam_hit
  import gam_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int IDX_W = ID_W - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_i,
  input  logic                 first_i,
  input  logic                 last_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  addr_mode_e           mode_i,
  input  logic [BYTE_W-1:0]    data_i,
  input  logic [ID_W-1:0]      node_id_i,
  input  logic [IDX_W-1:0]     tgt_idx_i,
  input  logic [BIT_SEL_W-1:0] tgt_bit_i,
  output logic                 sel_o
);
  localparam logic [IDX_W-1:0] LABEL_IDX = IDX_W'(1);

  logic hit_q, hit_now, hit_d, sel_q;

  always_comb begin
    if (mode_i == MODE_GROUP) hit_now = (idx_i == tgt_idx_i) && data_i[tgt_bit_i];
    else                      hit_now = (idx_i == LABEL_IDX) && (data_i == BYTE_W'(node_id_i));
  end

  assign hit_d = first_i ? hit_now : (hit_q | hit_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      sel_q <= last_i & hit_d;
      if (acc_i) hit_q <= last_i ? 1'b0 : hit_d;
    end
  end

  assign sel_o = sel_q;

  a_r6_sel_follows_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> $past(last_i));

  a_r10_direct_single_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_i && last_i && mode_i == MODE_DIRECT) |=> !sel_o);

  a_r11_no_late_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !last_i && hit_q && !first_i) |=> hit_q);
endmodule

// File: rtl/gam_matcher.sv
module gam_matcher
  import gam_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   node_id_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              sel_o
);
  localparam int IDX_W = ID_W + 1 - BIT_SEL_W;

  logic                 acc, first, last;
  logic [IDX_W-1:0]     idx, tgt_idx;
  logic [BIT_SEL_W-1:0] tgt_bit;
  addr_mode_e           mode;

  gam_target #(.ID_W(ID_W), .IDX_W(IDX_W)) u_target (
    .node_id_i (node_id_i),
    .tgt_idx_o (tgt_idx),
    .tgt_bit_o (tgt_bit)
  );

  gam_tracker #(.IDX_W(IDX_W)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sop_i      (sop_i),
    .eop_i      (eop_i),
    .type_bit_i (data_i[BYTE_W-1]),
    .acc_o      (acc),
    .first_o    (first),
    .last_o     (last),
    .idx_o      (idx),
    .mode_o     (mode)
  );

  gam_hit #(.ID_W(ID_W), .IDX_W(IDX_W)) u_hit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc),
    .first_i   (first),
    .last_i    (last),
    .idx_i     (idx),
    .mode_i    (mode),
    .data_i    (data_i),
    .node_id_i (node_id_i),
    .tgt_idx_i (tgt_idx),
    .tgt_bit_i (tgt_bit),
    .sel_o     (sel_o)
  );

  a_r1_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |=> !sel_o || !rst_ni);
endmodule

// File: tb/tb_gam_matcher.sv
module tb_gam_matcher;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] node_id = 8'd0;
  logic       valid = 1'b0, sop = 1'b0, eop = 1'b0;
  logic [7:0] data = 8'd0;
  logic       sel_o;

  int n_chk = 0, n_fail = 0, pulses = 0;
  logic [7:0] pkt [0:39];

  always #10 clk = ~clk;

  gam_matcher #(.ID_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .node_id_i(node_id), .valid_i(valid),
    .sop_i(sop), .eop_i(eop), .data_i(data), .sel_o(sel_o)
  );

  always @(posedge clk) if (sel_o) pulses++;

  // kind: 0 one device set, 1 all devices but arg, 2 direct label, 3 group with byte1 = arg
  typedef struct packed {
    logic [7:0] node;
    logic [1:0] kind;
    logic [7:0] arg;
    logic [5:0] len;
    logic       gap;
    logic       exp_sel;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{8'd3,   2'd0, 8'd3,   6'd1,  1'b0, 1'b1, 4'd3},  // R3 R10 single byte
    '{8'd3,   2'd0, 8'd4,   6'd4,  1'b0, 1'b0, 4'd3},  // R3 other device
    '{8'd6,   2'd0, 8'd6,   6'd1,  1'b1, 1'b1, 4'd3},  // R3 last bit of byte 0
    '{8'd7,   2'd0, 8'd7,   6'd2,  1'b0, 1'b1, 4'd4},  // R4 byte 1 bit 0
    '{8'd7,   2'd1, 8'd7,   6'd2,  1'b0, 1'b0, 4'd4},  // R4 all but self
    '{8'd8,   2'd0, 8'd8,   6'd2,  1'b1, 1'b1, 4'd4},  // R4 byte 1 bit 1
    '{8'd100, 2'd0, 8'd100, 6'd33, 1'b0, 1'b1, 4'd4},  // R4 byte 12 bit 5
    '{8'd100, 2'd1, 8'd100, 6'd33, 1'b1, 1'b0, 4'd4},  // R4
    '{8'd255, 2'd0, 8'd255, 6'd33, 1'b0, 1'b1, 4'd4},  // R4 byte 32 bit 0
    '{8'd255, 2'd0, 8'd255, 6'd32, 1'b0, 1'b0, 4'd7},  // R7 one byte short
    '{8'd100, 2'd0, 8'd100, 6'd13, 1'b0, 1'b1, 4'd7},  // R7 ends on target
    '{8'd100, 2'd0, 8'd100, 6'd12, 1'b0, 1'b0, 4'd7},  // R7 short
    '{8'd42,  2'd2, 8'd42,  6'd2,  1'b0, 1'b1, 4'd5},  // R5 label match
    '{8'd42,  2'd2, 8'd43,  6'd2,  1'b1, 1'b0, 4'd5},  // R5 label mismatch
    '{8'd0,   2'd2, 8'd0,   6'd2,  1'b0, 1'b1, 4'd5},  // R5 label 0
    '{8'd42,  2'd2, 8'd42,  6'd1,  1'b0, 1'b0, 4'd10}, // R10 direct one byte
    '{8'd42,  2'd2, 8'd42,  6'd5,  1'b0, 1'b1, 4'd11}, // R11 trailing bytes
    '{8'd0,   2'd1, 8'd0,   6'd33, 1'b0, 1'b0, 4'd3},  // R3 device 0 clear
    '{8'd42,  2'd3, 8'd42,  6'd6,  1'b0, 1'b0, 4'd2},  // R2 group byte1 == ID
    '{8'd9,   2'd3, 8'h04,  6'd2,  1'b0, 1'b1, 4'd2}   // R2 group byte1 bit 2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic build(input logic [1:0] kind, input logic [7:0] arg);
    int p;
    p = (arg < 8'd7) ? int'(arg) : int'(arg) + 1;
    for (int i = 0; i < 40; i++) pkt[i] = 8'h00;
    case (kind)
      2'd0: pkt[p / 8][p % 8] = 1'b1;
      2'd1: begin
        for (int i = 0; i < 40; i++) pkt[i] = 8'hFF;
        pkt[0][7] = 1'b0;
        pkt[p / 8][p % 8] = 1'b0;
      end
      2'd2: begin
        for (int i = 0; i < 40; i++) pkt[i] = 8'hFF;
        pkt[1] = arg;
      end
      default: pkt[1] = arg;
    endcase
  endtask

  task automatic send(input int len, input bit gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      valid = 1'b1; sop = (i == 0); eop = (i == len - 1); data = pkt[i];
      if (gap && i != len - 1) begin
        @(negedge clk);
        valid = 1'b0; sop = 1'b1; eop = 1'b1; data = 8'hFF;  // R8 ignored strobes
      end
    end
    @(negedge clk);
    valid = 1'b0; sop = 1'b0; eop = 1'b0; data = 8'h00;
  endtask

  task automatic drive(input bit s, input bit e, input logic [7:0] d);
    @(negedge clk);
    valid = 1'b1; sop = s; eop = e; data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; sop = 1'b0; eop = 1'b0; data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sel_o == 1'b0, "R1 in reset", sel_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(sel_o == 1'b0, "R1 after reset", sel_o, 0);

    for (int v = 0; v < NV; v++) begin
      node_id = VEC[v].node;
      build(VEC[v].kind, VEC[v].arg);
      pulses = 0;
      send(int'(VEC[v].len), VEC[v].gap);
      check(sel_o == VEC[v].exp_sel, $sformatf("vec %0d R%0d pulse", v, VEC[v].req),
            sel_o, VEC[v].exp_sel);
      @(negedge clk);
      check(sel_o == 1'b0, $sformatf("vec %0d R6 one cycle", v), sel_o, 0);
      check(pulses == int'(VEC[v].exp_sel), $sformatf("vec %0d R6 pulse count", v),
            pulses, VEC[v].exp_sel);
    end

    // R8: valid bytes after eop without sop are ignored
    node_id = 8'd3;
    pulses = 0;
    drive(1'b1, 1'b1, 8'h00);
    drive(1'b0, 1'b1, 8'h08);
    idle();
    check(sel_o == 1'b0, "R8 stray byte", sel_o, 0);
    @(negedge clk);
    check(pulses == 0, "R8 stray pulses", pulses, 0);

    // R9: restart drops earlier hit
    pulses = 0;
    drive(1'b1, 1'b0, 8'h08);
    drive(1'b1, 1'b1, 8'h00);
    idle();
    check(sel_o == 1'b0, "R9 restart drops hit", sel_o, 0);
    // R9: restart then hit
    drive(1'b1, 1'b0, 8'h00);
    drive(1'b1, 1'b1, 8'h08);
    idle();
    check(sel_o == 1'b1, "R9 restart then hit", sel_o, 1);

    // R6: back-to-back single-byte packets give two pulses
    drive(1'b1, 1'b1, 8'h08);
    drive(1'b1, 1'b1, 8'h08);
    check(sel_o == 1'b1, "R6 first of pair", sel_o, 1);
    idle();
    check(sel_o == 1'b1, "R6 second of pair", sel_o, 1);
    @(negedge clk);
    check(sel_o == 1'b0, "R6 pair ends", sel_o, 0);

    // R1: reset mid packet discards it
    drive(1'b1, 1'b0, 8'h08);
    idle();
    rst_ni = 1'b0;
    @(negedge clk);
    check(sel_o == 1'b0, "R1 mid reset", sel_o, 0);
    rst_ni = 1'b1;
    drive(1'b0, 1'b1, 8'h08);
    idle();
    check(sel_o == 1'b0, "R1 packet discarded", sel_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule